// File: doc/BRIEF.md
# Serial Instruction Register Access Controller

This block is the serial slave front end of a converter-style peripheral. A host selects it with an active-low chip select and clocks bytes in MSB first on a serial clock. The first byte of each access is an instruction. With bit 7 set, the instruction is a direct conversion command. Its gain and channel fields are stored at once and a conversion-start pulse is raised. No further bytes belong to it, so the next byte is read as a new instruction. With bit 7 clear, the instruction opens a read or write of one or two bytes in a small register file.

All serial lines are synchronized into the system clock domain and their edges are detected there. The serial clock must therefore stay low and stay high for at least four system clocks each. The converter itself is outside the block. Its result bytes and its PGA valid flags arrive on plain inputs, and the block returns them when the host reads the matching registers.

A two-byte access reaches the second byte at the partner address: one above an even address, one below an odd one. A host can therefore read the 12-bit result with either byte first.

Top module: `ser_cmd_regs`

## Requirements
- R1: An instruction byte with bit 7 = 1 loads its bits 6..4 into gain_o and its bits 3..0 into mux_o, and stores bits 6..0 into bits 6..0 of register 4. Bit 7 of register 4 keeps its value.
- R2: A direct instruction takes no data bytes. The next byte in the same selection is decoded as a new instruction.
- R3: With bit 7 = 0, bit 6 selects read (1) or write (0), bit 5 selects two bytes (1) or one byte (0), and bits 4..0 give the register address.
- R4: Registers 3, 4, 5, 6, 7 and 24 are readable and writable and reset to 0x00.
- R5: The second byte of a two-byte access uses the first address with bit 0 inverted: address+1 when the first address is even, address-1 when it is odd.
- R6: Read data leaves on sdo_o MSB first, one bit per serial clock. Each bit is driven after a falling edge and is valid at the next rising edge. Register 0 returns res_lo_i, register 1 returns res_hi_i, register 2 returns vld_i, and register 31 returns the ID parameter (default 0x01).
- R7: Writes to registers 0, 1, 2 and 31 and to unimplemented addresses change nothing. Reads from unimplemented addresses return 0x00.
- R8: A high chip select clears the bit count and returns the block to waiting for an instruction, so a partial byte has no effect. sdo_o is 0 while chip select is high.
- R9: After reset, gain_o and mux_o are 0, conv_start_o is 0 and sdo_o is 0.
- R10: conv_start_o is a single system-clock pulse. It is raised once for each completed direct instruction and never for any other byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Serial chip select, active low |
| sclk_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in, sampled on rising sclk |
| sdo_o | output | 1 | Serial data out, changes after falling sclk |
| res_lo_i | input | 8 | Result low byte with overrange flag (register 0) |
| res_hi_i | input | 8 | Result high byte (register 1) |
| vld_i | input | 8 | PGA valid flags (register 2) |
| conv_start_o | output | 1 | One-cycle conversion start pulse |
| gain_o | output | 3 | Gain code from register 4 |
| mux_o | output | 4 | Input channel code from register 4 |

## Verification
Each serial edge passes through a two-stage synchronizer and an edge register. A read bit therefore reaches sdo_o about three system clocks after the falling serial clock edge. Register writes, the gain and mux fields and the conversion pulse settle about three clocks after the eighth rising edge of a byte. The bench holds each serial clock phase for six system clocks. It samples sdo_o on a falling system clock edge just before it raises the serial clock. It checks gain_o, mux_o and the pulse count only after chip select has been high for several cycles.

// File: rtl/ser_pkg.sv
package ser_pkg;
  localparam int AW = 5;
  localparam int DW = 8;
  localparam int NUM_RW = 6;
  localparam logic [AW-1:0] RW_ADDR [NUM_RW] = '{5'd3, 5'd4, 5'd5, 5'd6, 5'd7, 5'd24};
  localparam int GM_IDX = 1;  // slot of register 4 in RW_ADDR
  localparam logic [AW-1:0] A_RES_LO  = 5'd0;
  localparam logic [AW-1:0] A_RES_HI  = 5'd1;
  localparam logic [AW-1:0] A_VALID   = 5'd2;
  localparam logic [AW-1:0] A_GAINMUX = 5'd4;
  localparam logic [AW-1:0] A_ID      = 5'd31;

  typedef enum logic [1:0] {ST_INSTR, ST_BYTE1, ST_BYTE2} seq_t;

  typedef struct packed {
    logic          rd;
    logic          wide;
    logic [AW-1:0] addr;
  } instr_t;
endpackage

// File: rtl/ser_sync.sv
module ser_sync #(
  parameter int STAGES = 2,
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[g] <= RST_VAL;
      else if (g == 0) stg[g] <= d_i;
      else stg[g] <= stg[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/ser_regfile.sv
module ser_regfile
  import ser_pkg::*;
#(
  parameter logic [DW-1:0] ID_VAL = 8'h01
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          dir_we_i,
  input  logic [DW-2:0] dir_data_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o,
  input  logic [DW-1:0] res_lo_i,
  input  logic [DW-1:0] res_hi_i,
  input  logic [DW-1:0] vld_i,
  output logic [DW-1:0] gainmux_o
);
  logic [DW-1:0]     rw_q [NUM_RW];
  logic [NUM_RW-1:0] hit;

  for (genvar g = 0; g < NUM_RW; g++) begin : g_hit
    assign hit[g] = (raddr_i == RW_ADDR[g]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NUM_RW; k++) rw_q[k] <= '0;
    end else begin
      for (int k = 0; k < NUM_RW; k++) begin
        if (we_i && waddr_i == RW_ADDR[k]) rw_q[k] <= wdata_i;
        else if (dir_we_i && RW_ADDR[k] == A_GAINMUX) rw_q[k][DW-2:0] <= dir_data_i;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (raddr_i)
      A_RES_LO: rdata_o = res_lo_i;
      A_RES_HI: rdata_o = res_hi_i;
      A_VALID:  rdata_o = vld_i;
      A_ID:     rdata_o = ID_VAL;
      default: begin
        for (int k = 0; k < NUM_RW; k++) if (hit[k]) rdata_o = rw_q[k];
      end
    endcase
  end

  assign gainmux_o = rw_q[GM_IDX];
endmodule

// File: rtl/ser_engine.sv
module ser_engine
  import ser_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_s_i,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic          sdi_s_i,
  input  logic [DW-1:0] rdata_i,
  output logic [AW-1:0] raddr_o,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [DW-1:0] wdata_o,
  output logic          dir_we_o,
  output logic [DW-2:0] dir_data_o,
  output logic          conv_start_o,
  output logic          sdo_o
);
  localparam int CW = $clog2(DW);

  seq_t          st_q;
  logic [CW-1:0] cnt_q;
  logic [DW-2:0] sr_q;
  instr_t        ins_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] tx_q;
  logic          sdo_q, conv_q;
  logic [DW-1:0] byte_w;
  logic          done_w;

  assign byte_w     = {sr_q, sdi_s_i};
  assign done_w     = rise_i && !cs_s_i && (cnt_q == CW'(DW-1));
  assign raddr_o    = (st_q == ST_INSTR) ? byte_w[AW-1:0] : (addr_q ^ AW'(1));
  assign dir_we_o   = done_w && (st_q == ST_INSTR) && byte_w[DW-1];
  assign dir_data_o = byte_w[DW-2:0];
  assign we_o       = done_w && (st_q != ST_INSTR) && !ins_q.rd;
  assign waddr_o    = addr_q;
  assign wdata_o    = byte_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_INSTR;
      cnt_q  <= '0;
      sr_q   <= '0;
      ins_q  <= '0;
      addr_q <= '0;
      tx_q   <= '0;
      sdo_q  <= 1'b0;
      conv_q <= 1'b0;
    end else begin
      conv_q <= dir_we_o;
      if (cs_s_i) begin
        st_q  <= ST_INSTR;
        cnt_q <= '0;
        tx_q  <= '0;
        sdo_q <= 1'b0;
      end else begin
        if (rise_i) begin
          sr_q  <= byte_w[DW-2:0];
          cnt_q <= cnt_q + 1'b1;
        end
        if (fall_i) begin
          sdo_q <= tx_q[DW-1];
          tx_q  <= {tx_q[DW-2:0], 1'b0};
        end
        if (done_w) begin
          case (st_q)
            ST_INSTR: if (!byte_w[DW-1]) begin
              ins_q  <= byte_w[DW-2:0];
              addr_q <= byte_w[AW-1:0];
              st_q   <= ST_BYTE1;
              if (byte_w[DW-2]) tx_q <= rdata_i;
            end
            ST_BYTE1: if (ins_q.wide) begin
              st_q   <= ST_BYTE2;
              addr_q <= addr_q ^ AW'(1);  // even +1, odd -1
              if (ins_q.rd) tx_q <= rdata_i;
            end else begin
              st_q <= ST_INSTR;
            end
            default: st_q <= ST_INSTR;
          endcase
        end
      end
    end
  end

  assign conv_start_o = conv_q;
  assign sdo_o        = sdo_q;
endmodule

// File: rtl/ser_cmd_regs.sv
module ser_cmd_regs
  import ser_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter logic [7:0] ID_VAL = 8'h01
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_ni,
  input  logic       sclk_i,
  input  logic       sdi_i,
  output logic       sdo_o,
  input  logic [7:0] res_lo_i,
  input  logic [7:0] res_hi_i,
  input  logic [7:0] vld_i,
  output logic       conv_start_o,
  output logic [2:0] gain_o,
  output logic [3:0] mux_o
);
  logic          cs_s, sclk_s, sdi_s, sclk_d;
  logic          rise_s, fall_s;
  logic [AW-1:0] raddr, waddr;
  logic [DW-1:0] rdata, wdata, gainmux;
  logic          we, dir_we;
  logic [DW-2:0] dir_data;

  ser_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sclk_i, sdi_i}),
    .q_o   ({cs_s, sclk_s, sdi_s})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_d <= 1'b0;
    else sclk_d <= sclk_s;
  end

  assign rise_s = sclk_s & ~sclk_d;
  assign fall_s = ~sclk_s & sclk_d;

  ser_engine u_eng (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_s_i      (cs_s),
    .rise_i      (rise_s),
    .fall_i      (fall_s),
    .sdi_s_i     (sdi_s),
    .rdata_i     (rdata),
    .raddr_o     (raddr),
    .we_o        (we),
    .waddr_o     (waddr),
    .wdata_o     (wdata),
    .dir_we_o    (dir_we),
    .dir_data_o  (dir_data),
    .conv_start_o(conv_start_o),
    .sdo_o       (sdo_o)
  );

  ser_regfile #(.ID_VAL(ID_VAL)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (we),
    .waddr_i   (waddr),
    .wdata_i   (wdata),
    .dir_we_i  (dir_we),
    .dir_data_i(dir_data),
    .raddr_i   (raddr),
    .rdata_o   (rdata),
    .res_lo_i  (res_lo_i),
    .res_hi_i  (res_hi_i),
    .vld_i     (vld_i),
    .gainmux_o (gainmux)
  );

  assign gain_o = gainmux[6:4];
  assign mux_o  = gainmux[3:0];
endmodule

// File: rtl/ser_cmd_regs_chk.sv
module ser_cmd_regs_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_s,
  input logic       rise_s,
  input logic       fall_s,
  input logic       sdo_o,
  input logic       conv_start_o,
  input logic [2:0] gain_o,
  input logic [3:0] mux_o
);
  // R10: pulse is one cycle wide
  a_r10_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o);

  // R2: pulse follows a byte completing on a rising serial edge
  a_r2_pulse_after_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> $past(rise_s));

  // R1: gain/mux only move right after a rising serial edge
  a_r1_gm_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({gain_o, mux_o}) |-> $past(rise_s));

  // R6: data out changes only after a falling edge or deselect
  a_r6_sdo_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdo_o) |-> ($past(fall_s) || $past(cs_s)));

  // R8: data out low while deselected
  a_r8_sdo_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cs_s) |-> !sdo_o);
endmodule

bind ser_cmd_regs ser_cmd_regs_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cs_s        (cs_s),
  .rise_s      (rise_s),
  .fall_s      (fall_s),
  .sdo_o       (sdo_o),
  .conv_start_o(conv_start_o),
  .gain_o      (gain_o),
  .mux_o       (mux_o)
);

// File: tb/sim_ser_cmd_regs.sv
`timescale 1ns/1ps
module sim_ser_cmd_regs;
  localparam int HALF = 6;
  localparam logic [7:0] ID = 8'h01;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cs_ni = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic sdo, conv;
  logic [7:0] res_lo = 8'h00, res_hi = 8'h00, vld = 8'h00;
  logic [2:0] gain;
  logic [3:0] mux;

  int n_run = 0, n_fail = 0, conv_cnt = 0;
  bit done = 0;
  logic [7:0] mdl [32];

  always #10 clk = ~clk;

  ser_cmd_regs u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .sclk_i(sclk), .sdi_i(sdi),
    .sdo_o(sdo), .res_lo_i(res_lo), .res_hi_i(res_hi), .vld_i(vld),
    .conv_start_o(conv), .gain_o(gain), .mux_o(mux)
  );

  always @(posedge clk) if (conv) conv_cnt++;

  function automatic bit writable(input logic [4:0] a);
    return a inside {5'd3, 5'd4, 5'd5, 5'd6, 5'd7, 5'd24};
  endfunction

  function automatic logic [7:0] exp_rd(input logic [4:0] a);
    case (a)
      5'd0: return res_lo;
      5'd1: return res_hi;
      5'd2: return vld;
      5'd31: return ID;
      default: return writable(a) ? mdl[a] : 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic spi_bit(input logic b, output logic r);
    sdi = b;
    repeat (HALF) @(negedge clk);
    r = sdo;
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) spi_bit(tx[i], rx[i]);
  endtask

  task automatic sel();
    @(negedge clk); cs_ni = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic desel();
    repeat (2) @(negedge clk); cs_ni = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic reg_write(input logic [4:0] a, input bit wide, input logic [7:0] d0, input logic [7:0] d1);
    logic [7:0] rx;
    sel();
    spi_byte({1'b0, 1'b0, wide, a}, rx);
    spi_byte(d0, rx);
    if (wide) spi_byte(d1, rx);
    desel();
    if (writable(a)) mdl[a] = d0;
    if (wide && writable(a ^ 5'd1)) mdl[a ^ 5'd1] = d1;
  endtask

  // R3 R5 R6 R7: read and compare both bytes
  task automatic reg_read(input logic [4:0] a, input bit wide, input string tag);
    logic [7:0] rx, r0, r1;
    sel();
    spi_byte({1'b0, 1'b1, wide, a}, rx);
    spi_byte(8'h00, r0);
    if (wide) spi_byte(8'h00, r1);
    desel();
    chk({tag, " byte0"}, r0, exp_rd(a));
    if (wide) chk({tag, " byte1"}, r1, exp_rd(a ^ 5'd1));
  endtask

  task automatic direct(input logic [6:0] f);
    logic [7:0] rx;
    int c0;
    c0 = conv_cnt;
    sel();
    spi_byte({1'b1, f}, rx);
    desel();
    mdl[4][6:0] = f;
    chk("R1 gain", gain, f[6:4]);
    chk("R1 mux", mux, f[3:0]);
    chk("R10 one pulse", conv_cnt - c0, 1);
  endtask

  initial begin
    logic [7:0] rx;
    int c0;
    void'($urandom(32'd4711));
    for (int i = 0; i < 32; i++) mdl[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);

    chk("R9 gain", gain, 0);
    chk("R9 mux", mux, 0);
    chk("R9 conv", conv, 0);
    chk("R9 sdo", sdo, 0);
    chk("R9 no pulse", conv_cnt, 0);

    res_lo = 8'hA5; res_hi = 8'h3C; vld = 8'h21;
    reg_read(5'd31, 0, "R6 id");
    reg_read(5'd3, 0, "R4 reset");
    reg_read(5'd24, 0, "R4 reset r24");
    reg_write(5'd3, 0, 8'h96, 8'h00);
    reg_read(5'd3, 0, "R4 wr8");
    reg_write(5'd6, 1, 8'h11, 8'h22);
    reg_read(5'd7, 1, "R5 odd");
    reg_read(5'd6, 1, "R5 even");
    reg_read(5'd0, 1, "R6 lo first");
    reg_read(5'd1, 1, "R6 hi first");
    reg_read(5'd2, 0, "R6 valid");
    reg_write(5'd0, 1, 8'hFF, 8'hFF);
    reg_read(5'd0, 1, "R7 ro");
    reg_write(5'd10, 0, 8'h77, 8'h00);
    reg_read(5'd10, 0, "R7 unimpl");
    reg_write(5'd24, 1, 8'hC3, 8'h5E);
    reg_read(5'd24, 1, "R7 r24 pair");
    reg_write(5'd31, 0, 8'h00, 8'h00);
    reg_read(5'd31, 0, "R7 id ro");

    reg_write(5'd4, 0, 8'h80, 8'h00);
    direct(7'h5B);
    reg_read(5'd4, 0, "R1 bit7 kept");

    // R2: direct followed by read in one selection
    c0 = conv_cnt;
    sel();
    spi_byte({1'b1, 7'h26}, rx);
    mdl[4][6:0] = 7'h26;
    spi_byte({3'b010, 5'd4}, rx);
    spi_byte(8'h00, rx);
    desel();
    chk("R2 next is instr", rx, mdl[4]);
    chk("R2 pulse", conv_cnt - c0, 1);

    // R8: partial byte then deselect
    c0 = conv_cnt;
    sel();
    for (int i = 0; i < 4; i++) spi_bit(1'b1, rx[0]);
    desel();
    chk("R8 sdo idle", sdo, 0);
    chk("R8 no pulse", conv_cnt - c0, 0);
    chk("R8 gain kept", {gain, mux}, mdl[4][6:0]);
    reg_write(5'd5, 0, 8'h5A, 8'h00);
    reg_read(5'd5, 0, "R8 realigned");

    for (int it = 0; it < 120; it++) begin
      logic [4:0] a;
      res_lo = 8'($urandom); res_hi = 8'($urandom); vld = 8'($urandom);
      a = ($urandom % 2) ? 5'($urandom) : 5'($urandom % 8);
      case ($urandom % 3)
        0: direct(7'($urandom));
        1: reg_write(a, 1'($urandom), 8'($urandom), 8'($urandom));
        default: reg_read(a, 1'($urandom), "R3 random");
      endcase
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule